// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

The engine stores incoming frames into a circular set of receive descriptors. Each descriptor owns a fixed-size buffer. A frame arrives one byte per cycle on a valid/last stream that also carries an error flag. The engine writes the bytes into the buffer of the current descriptor. When the last byte has been taken, it writes a completion word into that descriptor. The word holds the byte count, the status flags and the ownership bit. The engine then moves on to the next descriptor, and after the last descriptor it returns to the first.

The host finds a filled descriptor by its ownership bit and reads the frame through a word-wide buffer read port. It services descriptors in ring order. To hand a descriptor back, the host overwrites its word with the buffer size and ownership clear.

The engine checks ownership when a frame starts. If the current descriptor is still held by the host, or if no receive-on command has been given since reset, the whole frame is discarded and counted as missed. In the held-descriptor case the engine also stops, and it stays stopped until the host issues receive-on again.

Top module: `rxr_ring_engine`

## Requirements
- R1: After reset, every descriptor word reads 0x600 (1536, ownership bit 31 clear), `rx_running` is 0, `cur_idx` is 0 and `missed_count` is 0.
- R2: Completed frames go to descriptors 0, 1, 2, 3 in turn and then back to 0. `cur_idx` advances by one, wrapping from 3 to 0, on the clock edge that takes a frame's last byte.
- R3: Byte k of a frame placed in descriptor d is stored in buffer word d*384 + k/4, in bits [8*(k mod 4)+7 : 8*(k mod 4)]. `host_buf_rdata` returns the word at `host_buf_addr` one clock after the address is presented.
- R4: On the edge that takes a frame's last byte, the descriptor word is rewritten as follows: bit 31 set, bit 30 (more) clear, and bits [11:0] equal to the number of bytes stored, which includes the CRC bytes carried on the stream.
- R5: Bit 27 (packet good) is set only when no byte of the frame had `rx_err` high and the frame fitted in the buffer. A good frame of n bytes therefore reads 0x88000000 + n.
- R6: A frame longer than 1536 bytes keeps only its first 1536 bytes. Its descriptor reads length 1536 with bit 22 (too long) set and bit 27 clear, which is 0x80400600.
- R7: A frame that fits but has `rx_err` high on any byte is stored in full and reads bit 31 set, bit 27 clear, bit 22 clear and its true length.
- R8: A frame that starts before the first receive-on command after reset is not stored. It leaves every descriptor and `cur_idx` unchanged and raises `missed_count` by one.
- R9: A frame that starts while the current descriptor has bit 31 set is not stored, raises `missed_count` by one and clears `rx_running`. Every later frame is dropped in the same way until receive-on is issued.
- R10: A host write replaces the whole addressed descriptor word. After a held descriptor has been returned and `rx_on` has been pulsed, `rx_running` is 1 and the next frame lands in the descriptor where the engine stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | A stream byte is present this cycle |
| rx_data | input | 8 | Stream byte |
| rx_last | input | 1 | This byte ends the frame |
| rx_err | input | 1 | Byte received with a line error |
| rx_on | input | 1 | Receive-on command pulse |
| host_desc_we | input | 1 | Host write to a descriptor word |
| host_desc_idx | input | 2 | Descriptor selected for host read and write |
| host_desc_wdata | input | 32 | Descriptor word written by the host |
| host_desc_rdata | output | 32 | Selected descriptor word (combinational) |
| host_buf_addr | input | 11 | Buffer word address for host read |
| host_buf_rdata | output | 32 | Buffer word, one cycle after the address |
| cur_idx | output | 2 | Descriptor the next frame will use |
| rx_running | output | 1 | Engine accepts new frames |
| missed_count | output | 16 | Number of frames dropped |

## Verification
The descriptor completion word and the `cur_idx` step both appear on the edge that samples the last byte. The bench drives each byte at a falling edge and reads the descriptor at the falling edge that follows the last byte. The missed count and the fall of `rx_running` take effect on the edge that samples a dropped frame's first byte, so they are checked once the whole frame has been driven. Buffer words come back one clock after their address: the bench sets the address at one falling edge and samples the data at the next.

// File: rtl/rxr_pkg.sv
`timescale 1ns/1ps
package rxr_pkg;

    localparam int OWN_BIT  = 31;
    localparam int MORE_BIT = 30;
    localparam int GOOD_BIT = 27;
    localparam int LONG_BIT = 22;
    localparam int LEN_FW   = 12;

    // Builds the word the engine leaves in a descriptor when a frame ends.
    function automatic logic [31:0] mk_status(input logic [LEN_FW-1:0] len,
                                              input logic good,
                                              input logic too_long);
        logic [31:0] w;
        w = '0;
        w[OWN_BIT]  = 1'b1;
        w[MORE_BIT] = 1'b0;
        w[GOOD_BIT] = good;
        w[LONG_BIT] = too_long;
        w[LEN_FW-1:0] = len;
        return w;
    endfunction

endpackage

// File: rtl/rxr_desc_file.sv
`timescale 1ns/1ps
module rxr_desc_file #(
    parameter int NUM_DESC  = 4,
    parameter int IDX_W     = 2,
    parameter int FREE_WORD = 1536
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             eng_we,
    input  logic [IDX_W-1:0] eng_idx,
    input  logic [31:0]      eng_wdata,
    input  logic             host_we,
    input  logic [IDX_W-1:0] host_idx,
    input  logic [31:0]      host_wdata,
    input  logic [IDX_W-1:0] own_idx,
    output logic             own_o,
    output logic [31:0]      host_rdata
);
    import rxr_pkg::*;

    logic [31:0]         words_d [NUM_DESC];
    logic [31:0]         words_q [NUM_DESC];
    logic [NUM_DESC-1:0] own_vec;

    always_comb begin
        for (int i = 0; i < NUM_DESC; i++) words_d[i] = words_q[i];
        if (host_we) words_d[host_idx] = host_wdata;
        // Engine completion takes precedence over a same-cycle host write.
        if (eng_we)  words_d[eng_idx]  = eng_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_DESC; i++) words_q[i] <= 32'(FREE_WORD);
        end else begin
            for (int i = 0; i < NUM_DESC; i++) words_q[i] <= words_d[i];
        end
    end

    for (genvar g = 0; g < NUM_DESC; g++) begin : g_own
        assign own_vec[g] = words_q[g][OWN_BIT];
    end

    assign own_o      = own_vec[own_idx];
    assign host_rdata = words_q[host_idx];

endmodule

// File: rtl/rxr_buf_mem.sv
`timescale 1ns/1ps
module rxr_buf_mem #(
    parameter int DEPTH = 1536,
    parameter int AW    = 11
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [1:0]    lane,
    input  logic [7:0]    wbyte,
    input  logic [AW-1:0] raddr,
    output logic [31:0]   rdata
);
    logic [31:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr][8*lane +: 8] <= wbyte;
        rdata <= mem[raddr];
    end

endmodule

// File: rtl/rxr_fill_ctrl.sv
`timescale 1ns/1ps
module rxr_fill_ctrl #(
    parameter int NUM_DESC  = 4,
    parameter int BUF_BYTES = 1536,
    parameter int IDX_W     = 2,
    parameter int CNT_W     = 11,
    parameter int AW        = 11,
    parameter int WPB       = 384,
    parameter int MISS_W    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    input  logic              rx_last,
    input  logic              rx_err,
    input  logic              rx_on,
    input  logic              cur_owned,
    output logic              buf_we,
    output logic [AW-1:0]     buf_waddr,
    output logic [1:0]        buf_lane,
    output logic [7:0]        buf_wbyte,
    output logic              desc_we,
    output logic [IDX_W-1:0]  desc_idx,
    output logic [31:0]       desc_wdata,
    output logic [IDX_W-1:0]  cur_idx,
    output logic              running,
    output logic [MISS_W-1:0] missed_count
);
    import rxr_pkg::*;

    typedef struct packed {
        logic              run;
        logic              in_frame;
        logic              filling;
        logic [IDX_W-1:0]  cur;
        logic [CNT_W-1:0]  cnt;
        logic              too_long;
        logic              err_seen;
        logic [MISS_W-1:0] missed;
    } fill_st_t;

    fill_st_t st_d, st_q;

    logic             first_beat;
    logic             start_ok;
    logic             take;
    logic             room;
    logic             err_now;
    logic             long_now;
    logic [CNT_W-1:0] len_now;
    logic [IDX_W-1:0] cur_next;

    always_comb begin
        st_d       = st_q;
        buf_we     = 1'b0;
        buf_waddr  = '0;
        buf_lane   = '0;
        buf_wbyte  = rx_data;
        desc_we    = 1'b0;
        desc_idx   = st_q.cur;
        desc_wdata = '0;

        first_beat = rx_valid && !st_q.in_frame;
        start_ok   = st_q.run && !cur_owned;
        take       = rx_valid && (st_q.filling || (first_beat && start_ok));
        room       = st_q.cnt < CNT_W'(BUF_BYTES);
        err_now    = st_q.err_seen | rx_err;
        long_now   = st_q.too_long | !room;
        len_now    = room ? st_q.cnt + 1'b1 : st_q.cnt;
        cur_next   = (st_q.cur == IDX_W'(NUM_DESC - 1)) ? '0 : st_q.cur + 1'b1;

        if (rx_valid) st_d.in_frame = !rx_last;

        // Frame refused at its first byte: count it and stop the engine.
        if (first_beat && !start_ok) begin
            st_d.missed = st_q.missed + 1'b1;
            st_d.run    = 1'b0;
        end

        if (take) begin
            st_d.filling  = !rx_last;
            st_d.err_seen = err_now;
            st_d.too_long = long_now;
            if (room) begin
                buf_we    = 1'b1;
                buf_waddr = AW'(st_q.cur) * AW'(WPB) + AW'(st_q.cnt[CNT_W-1:2]);
                buf_lane  = st_q.cnt[1:0];
                st_d.cnt  = st_q.cnt + 1'b1;
            end
            if (rx_last) begin
                desc_we       = 1'b1;
                desc_wdata    = mk_status(LEN_FW'(len_now), !err_now && !long_now, long_now);
                st_d.cur      = cur_next;
                st_d.cnt      = '0;
                st_d.too_long = 1'b0;
                st_d.err_seen = 1'b0;
            end
        end

        // Receive-on wins over a same-cycle stop.
        if (rx_on) st_d.run = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cur_idx      = st_q.cur;
    assign running      = st_q.run;
    assign missed_count = st_q.missed;

endmodule

// File: rtl/rxr_ring_engine.sv
`timescale 1ns/1ps
module rxr_ring_engine #(
    parameter int NUM_DESC  = 4,
    parameter int BUF_BYTES = 1536,
    parameter int MISS_W    = 16,
    localparam int IDX_W    = (NUM_DESC > 1) ? $clog2(NUM_DESC) : 1,
    localparam int WPB      = BUF_BYTES / 4,
    localparam int DEPTH    = NUM_DESC * WPB,
    localparam int AW       = $clog2(DEPTH),
    localparam int CNT_W    = $clog2(BUF_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    input  logic              rx_last,
    input  logic              rx_err,
    input  logic              rx_on,
    input  logic              host_desc_we,
    input  logic [IDX_W-1:0]  host_desc_idx,
    input  logic [31:0]       host_desc_wdata,
    output logic [31:0]       host_desc_rdata,
    input  logic [AW-1:0]     host_buf_addr,
    output logic [31:0]       host_buf_rdata,
    output logic [IDX_W-1:0]  cur_idx,
    output logic              rx_running,
    output logic [MISS_W-1:0] missed_count
);
    logic             cur_owned;
    logic             eng_buf_we;
    logic [AW-1:0]    eng_buf_waddr;
    logic [1:0]       eng_buf_lane;
    logic [7:0]       eng_buf_wbyte;
    logic             eng_desc_we;
    logic [IDX_W-1:0] eng_desc_idx;
    logic [31:0]      eng_desc_wdata;

    rxr_fill_ctrl #(
        .NUM_DESC(NUM_DESC), .BUF_BYTES(BUF_BYTES), .IDX_W(IDX_W),
        .CNT_W(CNT_W), .AW(AW), .WPB(WPB), .MISS_W(MISS_W)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last),
        .rx_err(rx_err), .rx_on(rx_on), .cur_owned(cur_owned),
        .buf_we(eng_buf_we), .buf_waddr(eng_buf_waddr),
        .buf_lane(eng_buf_lane), .buf_wbyte(eng_buf_wbyte),
        .desc_we(eng_desc_we), .desc_idx(eng_desc_idx),
        .desc_wdata(eng_desc_wdata),
        .cur_idx(cur_idx), .running(rx_running), .missed_count(missed_count)
    );

    rxr_desc_file #(
        .NUM_DESC(NUM_DESC), .IDX_W(IDX_W), .FREE_WORD(BUF_BYTES)
    ) u_desc (
        .clk(clk), .rst_n(rst_n),
        .eng_we(eng_desc_we), .eng_idx(eng_desc_idx), .eng_wdata(eng_desc_wdata),
        .host_we(host_desc_we), .host_idx(host_desc_idx),
        .host_wdata(host_desc_wdata),
        .own_idx(cur_idx), .own_o(cur_owned), .host_rdata(host_desc_rdata)
    );

    rxr_buf_mem #(
        .DEPTH(DEPTH), .AW(AW)
    ) u_buf (
        .clk(clk), .we(eng_buf_we), .waddr(eng_buf_waddr), .lane(eng_buf_lane),
        .wbyte(eng_buf_wbyte), .raddr(host_buf_addr), .rdata(host_buf_rdata)
    );

endmodule

// File: rtl/rxr_ring_engine_chk.sv
`timescale 1ns/1ps
module rxr_ring_engine_chk #(
    parameter int NUM_DESC  = 4,
    parameter int BUF_BYTES = 1536,
    parameter int MISS_W    = 16,
    parameter int IDX_W     = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rx_on,
    input logic              eng_desc_we,
    input logic [IDX_W-1:0]  eng_desc_idx,
    input logic [31:0]       eng_desc_wdata,
    input logic [IDX_W-1:0]  cur_idx,
    input logic              rx_running,
    input logic [MISS_W-1:0] missed_count
);
    AST_DONE_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
        eng_desc_we |-> (eng_desc_wdata[31] && !eng_desc_wdata[30])); // R4

    AST_GOOD_NOT_LONG: assert property (@(posedge clk) disable iff (!rst_n)
        eng_desc_we |-> !(eng_desc_wdata[27] && eng_desc_wdata[22])); // R5

    AST_LEN_CAPPED: assert property (@(posedge clk) disable iff (!rst_n)
        eng_desc_we |-> (eng_desc_wdata[11:0] <= 12'(BUF_BYTES) && eng_desc_wdata[11:0] != 12'd0)); // R6

    AST_RING_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        eng_desc_we |=> (cur_idx == (($past(eng_desc_idx) == IDX_W'(NUM_DESC - 1)) ? '0 : $past(eng_desc_idx) + 1'b1))); // R2

    AST_RUN_AFTER_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        rx_on |=> rx_running); // R10

    AST_MISS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (MISS_W'(missed_count - $past(missed_count)) <= MISS_W'(1))); // R8

endmodule

bind rxr_ring_engine rxr_ring_engine_chk #(
    .NUM_DESC(NUM_DESC), .BUF_BYTES(BUF_BYTES), .MISS_W(MISS_W), .IDX_W(IDX_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .rx_on(rx_on),
    .eng_desc_we(eng_desc_we), .eng_desc_idx(eng_desc_idx),
    .eng_desc_wdata(eng_desc_wdata), .cur_idx(cur_idx),
    .rx_running(rx_running), .missed_count(missed_count)
);

// File: tb/sim_rxr_ring_engine.sv
`timescale 1ns/1ps
module sim_rxr_ring_engine;

    localparam int BUF = 1536;
    localparam int WPB = BUF / 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rx_last = 1'b0;
    logic        rx_err = 1'b0;
    logic        rx_on = 1'b0;
    logic        host_desc_we = 1'b0;
    logic [1:0]  host_desc_idx = '0;
    logic [31:0] host_desc_wdata = '0;
    logic [31:0] host_desc_rdata;
    logic [10:0] host_buf_addr = '0;
    logic [31:0] host_buf_rdata;
    logic [1:0]  cur_idx;
    logic        rx_running;
    logic [15:0] missed_count;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    rxr_ring_engine u0 (
        .clk(clk), .rst_n(rst_n),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last),
        .rx_err(rx_err), .rx_on(rx_on),
        .host_desc_we(host_desc_we), .host_desc_idx(host_desc_idx),
        .host_desc_wdata(host_desc_wdata), .host_desc_rdata(host_desc_rdata),
        .host_buf_addr(host_buf_addr), .host_buf_rdata(host_buf_rdata),
        .cur_idx(cur_idx), .rx_running(rx_running), .missed_count(missed_count)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic read_desc(input int idx, output logic [31:0] w);
        @(negedge clk);
        host_desc_idx = 2'(idx);
        #1 w = host_desc_rdata;
    endtask

    task automatic chk_desc(input string req, input int idx, input logic [31:0] exp);
        logic [31:0] w;
        read_desc(idx, w);
        chk(req, w, exp);
    endtask

    task automatic send_frame(input int len, input logic [7:0] seed, input int err_pos);
        for (int k = 0; k < len; k++) begin
            @(negedge clk);
            rx_valid = 1'b1;
            rx_data  = seed + 8'(k);
            rx_last  = (k == len - 1);
            rx_err   = (k == err_pos);
        end
        @(negedge clk);
        rx_valid = 1'b0;
        rx_last  = 1'b0;
        rx_err   = 1'b0;
    endtask

    task automatic pulse_on();
        @(negedge clk);
        rx_on = 1'b1;
        @(negedge clk);
        rx_on = 1'b0;
    endtask

    task automatic host_write(input int idx, input logic [31:0] val);
        @(negedge clk);
        host_desc_we    = 1'b1;
        host_desc_idx   = 2'(idx);
        host_desc_wdata = val;
        @(negedge clk);
        host_desc_we    = 1'b0;
    endtask

    // Reads back a descriptor's buffer and compares every stored byte.
    task automatic chk_buf(input string req, input int idx, input int len, input logic [7:0] seed);
        int n;
        int bad;
        logic [31:0] first_act;
        logic [31:0] first_exp;
        n = (len < BUF) ? len : BUF;
        bad = 0;
        first_act = '0;
        first_exp = '0;
        for (int w = 0; w < (n + 3) / 4; w++) begin
            logic [31:0] got;
            logic [31:0] want;
            logic [31:0] mask;
            @(negedge clk);
            host_buf_addr = 11'(idx * WPB + w);
            @(negedge clk);
            got  = host_buf_rdata;
            want = '0;
            mask = '0;
            for (int b = 0; b < 4; b++) begin
                if (w * 4 + b < n) begin
                    want[8*b +: 8] = seed + 8'(w * 4 + b);
                    mask[8*b +: 8] = 8'hFF;
                end
            end
            if ((got & mask) !== want) begin
                if (bad == 0) begin
                    first_act = got & mask;
                    first_exp = want;
                end
                bad++;
            end
        end
        chk(req, first_act, first_exp);
        chk(req, 32'(bad), 32'd0);
    endtask

    task automatic t_reset();
        for (int i = 0; i < 4; i++) chk_desc("R1 desc reset", i, 32'h0000_0600);
        chk("R1 running", 32'(rx_running), 32'd0);
        chk("R1 cur_idx", 32'(cur_idx), 32'd0);
        chk("R1 missed", 32'(missed_count), 32'd0);
    endtask

    task automatic t_stopped();
        send_frame(64, 8'h10, -1);
        chk("R8 missed", 32'(missed_count), 32'd1);
        chk("R8 cur_idx", 32'(cur_idx), 32'd0);
        chk_desc("R8 desc0 untouched", 0, 32'h0000_0600);
        pulse_on();
        chk("R10 running after on", 32'(rx_running), 32'd1);
    endtask

    task automatic t_ring();
        int lens [4];
        logic [7:0] seeds [4];
        lens  = '{64, 60, 100, 65};
        seeds = '{8'h20, 8'h40, 8'h60, 8'h80};
        for (int i = 0; i < 4; i++) begin
            send_frame(lens[i], seeds[i], -1);
            chk_desc("R4 R5 good frame word", i, 32'h8800_0000 | 32'(lens[i]));
            chk("R2 cur_idx step", 32'(cur_idx), 32'((i + 1) % 4));
            chk_buf("R3 buffer bytes", i, lens[i], seeds[i]);
        end
    endtask

    task automatic t_owned();
        send_frame(64, 8'h55, -1);
        chk("R9 missed", 32'(missed_count), 32'd2);
        chk("R9 running cleared", 32'(rx_running), 32'd0);
        chk_desc("R9 desc0 kept", 0, 32'h8800_0040);
        send_frame(40, 8'h66, -1);
        chk("R9 still dropping", 32'(missed_count), 32'd3);
        chk("R9 cur_idx held", 32'(cur_idx), 32'd0);
    endtask

    task automatic t_return();
        host_write(0, 32'h0000_0600);
        host_write(1, 32'h0000_0600);
        chk_desc("R10 host write", 0, 32'h0000_0600);
        send_frame(30, 8'h77, -1);
        chk("R9 dropped before on", 32'(missed_count), 32'd4);
        pulse_on();
        chk("R10 running", 32'(rx_running), 32'd1);
        send_frame(70, 8'hA0, 5);
        chk_desc("R7 error frame word", 0, 32'h8000_0046);
        chk("R10 resumed slot", 32'(cur_idx), 32'd1);
        chk_buf("R7 error frame stored", 0, 70, 8'hA0);
    endtask

    task automatic t_long();
        send_frame(1540, 8'h33, -1);
        chk_desc("R6 too long word", 1, 32'h8040_0600);
        chk("R6 cur_idx", 32'(cur_idx), 32'd2);
        chk_desc("R6 desc2 untouched", 2, 32'h8800_0064);
        chk_buf("R6 truncated buffer", 1, 1540, 8'h33);
        chk("R6 missed unchanged", 32'(missed_count), 32'd4);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_stopped();
        t_ring();
        t_owned();
        t_return();
        t_long();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule